// File: doc/BRIEF.md
# Single-Bit Manipulate-and-Skip Unit

This unit executes the single-bit instructions of a small 4-bit processor on a nibble-wide data memory. For each instruction it receives an opcode, a memory address and a bit index, together with a one-cycle start strobe.

In the first cycle it issues a read on a synchronous memory port. In the second cycle it forms the result and raises a done pulse. On that same cycle it may write one modified nibble back, update its carry flag, or latch a skip request.

The skip request is a level that stays high until the next instruction is accepted. The external sequencer uses it to discard the following instruction, which is where the extra skip cycles come from. That sequencer, instruction fetch and address-area decoding are outside this unit.

Top module: `bit_op_unit`

## Requirements
- R1: The opcode `op_i` is encoded as follows: 0 set, 1 clear, 2 skip-if-one, 3 skip-if-zero, 4 skip-if-one-and-clear, 5 carry AND, 6 carry OR, 7 carry XOR. A start accepted while idle drives `mem_re_o`=1 with `mem_addr_o`=`addr_i` in that same cycle. `done_o` and `busy_o` are high in the next cycle, so every instruction takes two cycles.
- R2: Set (0) writes the read nibble back on the done cycle, with bit `bit_i` forced to 1 and the other three bits unchanged.
- R3: Clear (1) writes the read nibble back on the done cycle, with bit `bit_i` forced to 0 and the other bits unchanged.
- R4: Skip-if-one (2) and skip-if-zero (3) never write memory. From the cycle after done, `skip_o` is 1 exactly when the tested bit was 1 (for opcode 2) or 0 (for opcode 3).
- R5: Skip-if-one-and-clear (4) sets `skip_o` and writes the nibble back with the bit cleared when the bit is 1. When the bit is 0 it gives no write strobe and no skip.
- R6: The carry operations (5, 6, 7) replace `cy_o` with `cy_o` AND, OR or XOR the tested bit. The new value is visible from the cycle after done. These operations never write memory and never request a skip. `cy_o` changes at no other time.
- R7: `skip_o` holds its value until the next accepted start, which clears it. The next cycle then shows 0, unless that instruction skips.
- R8: The reset `rst_ni` (active low, asynchronous) clears `cy_o`, `skip_o`, `busy_o` and `done_o`.
- R9: A start presented while `busy_o` is high is ignored: it causes no read, no write and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one instruction |
| op_i | input | 3 | Opcode (encoding in R1) |
| addr_i | input | AW | Nibble address |
| bit_i | input | log2(DW) | Bit index within the nibble |
| busy_o | output | 1 | Second cycle of an instruction in progress |
| done_o | output | 1 | Instruction completes this cycle |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after the read |
| cy_o | output | 1 | Carry flag |
| skip_o | output | 1 | Pending skip request |

## Verification
The bench sweeps every opcode over every bit index, every nibble value and both carry values, checking each result against arithmetic done in the bench.

The corner cases it targets are these:
- The test-and-clear miss. A design that writes unconditionally would rewrite the nibble, and may corrupt it.
- The untouched neighbour bits. A wrong mask would flip them.
- Carry stability on non-carry operations. A design that updates the flag on every done pulse would lose it.
- How long a skip request is held. It must neither fall on its own nor survive the next start.
- A start that arrives on the done cycle. A design that accepted it would issue an extra read and write.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [2:0] {
    OP_SET  = 3'd0,
    OP_CLR  = 3'd1,
    OP_SK1  = 3'd2,
    OP_SK0  = 3'd3,
    OP_SK1C = 3'd4,
    OP_CAND = 3'd5,
    OP_COR  = 3'd6,
    OP_CXOR = 3'd7
  } bitop_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } bitop_state_e;
endpackage

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bit_i,
  output logic          accept_o,
  output logic          exec_o,
  output bitop_e        op_q_o,
  output logic [AW-1:0] addr_q_o,
  output logic [BW-1:0] bit_q_o
);
  bitop_state_e state_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign exec_o   = (state_q == ST_EXEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q_o   <= OP_SET;
      addr_q_o <= '0;
      bit_q_o  <= '0;
    end else begin
      state_q <= accept_o ? ST_EXEC : ST_IDLE;
      if (accept_o) begin
        op_q_o   <= bitop_e'(op_i);
        addr_q_o <= addr_i;
        bit_q_o  <= bit_i;
      end
    end
  end

  p_exec_follows_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> exec_o);
  p_no_back_to_back_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DW = 4,
  parameter int BW = 2
) (
  input  bitop_e        op_i,
  input  logic [BW-1:0] bit_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          cy_i,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic          skip_o,
  output logic          cy_we_o,
  output logic          cy_next_o
);
  logic [DW-1:0] mask;
  logic          tbit;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (bit_i == BW'(i));
  end

  assign tbit = |(rdata_i & mask);

  always_comb begin
    wdata_o   = rdata_i;
    we_o      = 1'b0;
    skip_o    = 1'b0;
    cy_we_o   = 1'b0;
    cy_next_o = cy_i;
    unique case (op_i)
      OP_SET:  begin wdata_o = rdata_i | mask;  we_o = 1'b1; end
      OP_CLR:  begin wdata_o = rdata_i & ~mask; we_o = 1'b1; end
      OP_SK1:  skip_o = tbit;
      OP_SK0:  skip_o = !tbit;
      OP_SK1C: begin wdata_o = rdata_i & ~mask; we_o = tbit; skip_o = tbit; end
      OP_CAND: begin cy_we_o = 1'b1; cy_next_o = cy_i & tbit; end
      OP_COR:  begin cy_we_o = 1'b1; cy_next_o = cy_i | tbit; end
      OP_CXOR: begin cy_we_o = 1'b1; cy_next_o = cy_i ^ tbit; end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitop_flags.sv
module bitop_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic exec_i,
  input  logic skip_req_i,
  input  logic cy_we_i,
  input  logic cy_next_i,
  output logic cy_o,
  output logic skip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cy_o   <= 1'b0;
      skip_o <= 1'b0;
    end else begin
      if (accept_i) skip_o <= 1'b0;
      else if (exec_i && skip_req_i) skip_o <= 1'b1;
      if (exec_i && cy_we_i) cy_o <= cy_next_i;
    end
  end

  p_cy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(cy_o));
  p_skip_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !skip_o);
  p_skip_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_o && !accept_i) |=> skip_o);
endmodule

// File: rtl/bit_op_unit.sv
module bit_op_unit
  import bitop_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 4,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bit_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          cy_o,
  output logic          skip_o
);
  logic          accept, exec, alu_we, alu_skip, cy_we, cy_next;
  bitop_e        op_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] bit_q;

  bitop_ctrl #(.AW(AW), .BW(BW)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .op_i, .addr_i, .bit_i,
    .accept_o(accept), .exec_o(exec), .op_q_o(op_q),
    .addr_q_o(addr_q), .bit_q_o(bit_q)
  );

  bitop_alu #(.DW(DW), .BW(BW)) i_alu (
    .op_i(op_q), .bit_i(bit_q), .rdata_i(mem_rdata_i), .cy_i(cy_o),
    .wdata_o(mem_wdata_o), .we_o(alu_we), .skip_o(alu_skip),
    .cy_we_o(cy_we), .cy_next_o(cy_next)
  );

  bitop_flags i_flags (
    .clk_i, .rst_ni, .accept_i(accept), .exec_i(exec),
    .skip_req_i(alu_skip), .cy_we_i(cy_we), .cy_next_i(cy_next),
    .cy_o, .skip_o
  );

  assign busy_o     = exec;
  assign done_o     = exec;
  assign mem_re_o   = accept;
  assign mem_we_o   = exec && alu_we;
  assign mem_addr_o = exec ? addr_q : addr_i;

  p_one_bit_changes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_wdata_o ^ mem_rdata_i) <= 1));
  p_test_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_SK1 || op_q == OP_SK0)) |-> !mem_we_o);
  p_tc_write_on_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_SK1C && mem_we_o) |=> skip_o);
  p_write_in_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> done_o && !mem_re_o);
  p_ignore_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !mem_re_o);
endmodule

// File: tb/test_bit_op_unit.sv
module test_bit_op_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [AW-1:0] addr = '0;
  logic [1:0] bidx = '0;
  logic busy, done, re, we, cy, skip;
  logic [AW-1:0] maddr;
  logic [DW-1:0] wdata, rdata;
  logic [DW-1:0] mem [64];

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_op_unit #(.AW(AW), .DW(DW)) i_bit_op_unit (
    .clk_i(clk), .rst_ni, .start_i(start), .op_i(op), .addr_i(addr), .bit_i(bidx),
    .busy_o(busy), .done_o(done), .mem_re_o(re), .mem_we_o(we),
    .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .cy_o(cy), .skip_o(skip)
  );

  always @(posedge clk) begin
    if (re) rdata <= mem[maddr];
    if (we) mem[maddr] <= wdata;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic s_done, s_we, s_re_ok;
  logic [DW-1:0] s_wdata;

  task automatic run_op(input logic [2:0] o, input logic [AW-1:0] a, input logic [1:0] b);
    @(negedge clk);
    start = 1'b1; op = o; addr = a; bidx = b;
    #1 s_re_ok = re && (maddr == a);
    @(negedge clk);
    start = 1'b0;
    s_done = done; s_we = we; s_wdata = wdata;
    @(negedge clk);
  endtask

  task automatic preset_cy(input logic c);
    mem[63] = 4'b0001;
    run_op(c ? 3'd6 : 3'd5, 6'd63, c ? 2'd0 : 2'd1);
  endtask

  initial begin
    rdata = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!cy && !skip && !busy && !done && !re && !we, "R8 reset state",
          {cy, skip, busy, done}, 0);
    rst_ni = 1'b1;

    for (int o = 0; o < 8; o++)
      for (int b = 0; b < 4; b++)
        for (int d = 0; d < 16; d++)
          for (int c = 0; c < 2; c++) begin
            logic [3:0] old, ew;
            logic tb, eskip, ecy, ewe;
            int a;
            a = (o * 7 + d) % 60;
            preset_cy(c[0]);
            old = d[3:0];
            mem[a] = old;
            tb = old[b];
            ew = old;
            ewe = 1'b0; eskip = 1'b0; ecy = c[0];
            case (o)
              0: begin ewe = 1'b1; ew = old | (4'b1 << b); end
              1: begin ewe = 1'b1; ew = old & ~(4'b1 << b); end
              2: eskip = tb;
              3: eskip = !tb;
              4: begin ewe = tb; eskip = tb; ew = old & ~(4'b1 << b); end
              5: ecy = c[0] & tb;
              6: ecy = c[0] | tb;
              default: ecy = c[0] ^ tb;
            endcase
            run_op(o[2:0], a[AW-1:0], b[1:0]);
            check(s_re_ok, "R1 read strobe on start", int'(s_re_ok), 1);
            check(s_done, "R1 done on second cycle", int'(s_done), 1);
            check(s_we == ewe, o == 4 ? "R5 write strobe" : (o < 2 ? "R2/R3 write strobe" : "R4/R6 no write"),
                  int'(s_we), int'(ewe));
            if (ewe)
              check(s_wdata == ew, o == 0 ? "R2 set data" : (o == 1 ? "R3 clear data" : "R5 cleared data"),
                    int'(s_wdata), int'(ew));
            check(mem[a] == (ewe ? ew : old), "R2 R3 R5 memory contents", int'(mem[a]),
                  int'(ewe ? ew : old));
            check(skip == eskip, o == 4 ? "R5 skip" : "R4 R7 skip", int'(skip), int'(eskip));
            check(cy == ecy, "R6 carry", int'(cy), int'(ecy));
          end

    // R7: skip held across idle cycles, cleared by next start
    mem[5] = 4'b0100;
    run_op(3'd2, 6'd5, 2'd2);
    repeat (3) @(negedge clk);
    check(skip == 1'b1, "R7 skip held", int'(skip), 1);
    @(negedge clk);
    start = 1'b1; op = 3'd0; addr = 6'd6; bidx = 2'd0;
    @(negedge clk);
    start = 1'b0;
    check(skip == 1'b0, "R7 skip cleared by start", int'(skip), 0);
    @(negedge clk);

    // R9: start while busy is ignored
    mem[7] = 4'b0000;
    mem[8] = 4'b0000;
    @(negedge clk);
    start = 1'b1; op = 3'd0; addr = 6'd7; bidx = 2'd1;
    @(negedge clk);
    op = 3'd0; addr = 6'd8; bidx = 2'd3;
    #1 check(!re, "R9 no read while busy", int'(re), 0);
    @(negedge clk);
    start = 1'b0;
    check(!done, "R9 no done for ignored start", int'(done), 0);
    repeat (2) @(negedge clk);
    check(mem[8] == 4'b0000, "R9 ignored start leaves memory", int'(mem[8]), 0);
    check(mem[7] == 4'b0010, "R2 accepted set", int'(mem[7]), 2);

    // R8: reset mid-state clears carry and skip
    preset_cy(1'b1);
    mem[9] = 4'b0001;
    run_op(3'd2, 6'd9, 2'd0);
    rst_ni = 1'b0;
    #1 check(!cy && !skip && !busy, "R8 reset clears flags", {cy, skip, busy}, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule